// File: doc/BRIEF.md
# Demagnetization Event Generator

This block marks the end of winding demagnetization in each commutation step of a sensorless brushless motor controller. Two sources can produce the event. The first is a hardware source: a filtered edge on the sampled comparator output of the non-driven winding. The second is a simulated source: an 8-bit step counter, cleared at every commutation, reaching a stored demagnetization time. The block can use either source or both, and the first source to respond ends the step. When the hardware source is on, each hardware event stores the counter value, so later steps can reuse it as a simulated time. With only the simulated source enabled, the block acts as a programmable blanking interval between commutation and zero-crossing detection.

Software writes the source enables and the filter depth to a staging copy. That copy takes effect at the next commutation strobe. The stored time has its own staging copy, which moves to the working copy on a separate update strobe. The cycle after each commutation, the block checks whether the stored time is already due. If it is, the event fires at once and the stored time is replaced by the current count. Each event sets a sticky flag, which drives an interrupt line through a mask.

Top module: `demag_event_gen`

## Requirements
- R1: After reset, demag_evt_o, demag_flag_o and irq_o are 0 and demag_val_o is 0.
- R2: cfg_wr_i stores the enables and the filter depth in a staging copy. That copy becomes active only in the cycle after a comm_i strobe, so a write has no effect on events in the step that is already running.
- R3: When rising_i is 1, a sample with sense_i=1 qualifies; when rising_i is 0, a sample with sense_i=0 qualifies. A sample is taken in each cycle with sample_en_i=1. The hardware source fires on the (filter depth + 1)th consecutive qualifying sample, and only after at least one non-qualifying sample since the last comm_i. A non-qualifying sample or a comm_i restarts the count.
- R4: A hardware-source event while the hardware enable is active loads demag_val_o with the count_i value of the triggering cycle.
- R5: With the simulated enable active, count_i equal to demag_val_o triggers an event.
- R6: With both enables active, whichever source responds first gives the single event of the step.
- R7: demag_evt_o is a one-cycle pulse, one clock after the triggering input cycle. At most one event occurs between two comm_i strobes. Later hardware edges or matches in the same step are ignored and do not change demag_val_o. No event occurs before the first comm_i.
- R8: demag_wr_i writes demag_wdata_i to a staging copy. rupd_i moves that copy to demag_val_o on the next clock. A capture or overwrite in the same cycle takes priority.
- R9: In the cycle after comm_i, with the simulated enable active, demag_val_o <= count_i fires the event immediately (this includes equality). demag_val_o is then replaced with that count_i value.
- R10: demag_flag_o is set together with each event and stays set until a cycle with flag_clr_i=1 and no new event. If a set and a clear land in the same cycle, the set wins. irq_o equals demag_flag_o gated by irq_mask_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| comm_i | input | 1 | Commutation strobe; re-arms the step |
| rupd_i | input | 1 | Moves the staged demag time into the working copy |
| count_i | input | CNT_W | Step counter, cleared at commutation |
| sample_en_i | input | 1 | Comparator sample valid |
| sense_i | input | 1 | Sampled comparator level of the non-driven winding |
| rising_i | input | 1 | Edge polarity: 1 = high samples qualify |
| cfg_wr_i | input | 1 | Write strobe for the staged mode and filter depth |
| cfg_hw_en_i | input | 1 | Staged hardware-source enable |
| cfg_sim_en_i | input | 1 | Staged simulated-source enable |
| cfg_filt_i | input | FILT_W | Staged filter depth (extra samples required) |
| demag_wr_i | input | 1 | Write strobe for the staged demag time |
| demag_wdata_i | input | CNT_W | Staged demag time value |
| irq_mask_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear of the sticky flag |
| demag_evt_o | output | 1 | One-cycle demagnetization event |
| demag_flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Masked interrupt request |
| demag_val_o | output | CNT_W | Working demag time |

## Verification
The bench uses the defaults CNT_W=8 and FILT_W=4. This allows filter depths up to 15 and the full counter range, although the bench jumps count_i directly to the values of interest rather than sweeping it. A depth of 2 tests restart on a broken run; a depth of 0 tests single-sample edges when both sources race. The 8-bit width keeps the commutation check at the boundary cases below, equal to and above the count within a few cycles.

// File: rtl/demag_pkg.sv
package demag_pkg;

    typedef struct packed {
        logic hw_en;
        logic sim_en;
    } mode_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HW   = 2'd1,
        SRC_SIM  = 2'd2,
        SRC_LATE = 2'd3
    } src_e;

endpackage

// File: rtl/demag_cfg_shadow.sv
module demag_cfg_shadow
    import demag_pkg::*;
#(
    parameter int unsigned FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              hw_en_i,
    input  logic              sim_en_i,
    input  logic [FILT_W-1:0] filt_i,
    input  logic              comm_i,
    output mode_t             act_mode_o,
    output logic [FILT_W-1:0] act_filt_o
);

    typedef struct packed {
        mode_t             pre_mode;
        logic [FILT_W-1:0] pre_filt;
        mode_t             act_mode;
        logic [FILT_W-1:0] act_filt;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.pre_mode.hw_en  = hw_en_i;
            st_d.pre_mode.sim_en = sim_en_i;
            st_d.pre_filt        = filt_i;
        end
        if (comm_i) begin
            st_d.act_mode = st_q.pre_mode;
            st_d.act_filt = st_q.pre_filt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_mode_o = st_q.act_mode;
    assign act_filt_o = st_q.act_filt;

    // R2
    act_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !comm_i |=> ($stable(st_q.act_mode) && $stable(st_q.act_filt)));

endmodule

// File: rtl/demag_edge_filter.sv
module demag_edge_filter #(
    parameter int unsigned FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              comm_i,
    input  logic              sample_en_i,
    input  logic              sense_i,
    input  logic              rising_i,
    input  logic [FILT_W-1:0] filt_i,
    output logic              hit_o
);

    typedef struct packed {
        logic              seen;
        logic              done;
        logic [FILT_W-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;
    logic  qual, nonqual;

    assign qual    = sample_en_i && (sense_i == rising_i);
    assign nonqual = sample_en_i && (sense_i != rising_i);

    always_comb begin
        st_d  = st_q;
        hit_o = 1'b0;
        if (comm_i) begin
            st_d = '0;
        end else if (nonqual) begin
            st_d.seen = 1'b1;
            st_d.done = 1'b0;
            st_d.cnt  = '0;
        end else if (qual && st_q.seen && !st_q.done) begin
            if (st_q.cnt == filt_i) begin
                hit_o     = 1'b1;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);

    // R3
    hit_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (st_q.seen && (sense_i == rising_i)));

endmodule

// File: rtl/demag_event_gen.sv
module demag_event_gen
    import demag_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              comm_i,
    input  logic              rupd_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              sample_en_i,
    input  logic              sense_i,
    input  logic              rising_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_hw_en_i,
    input  logic              cfg_sim_en_i,
    input  logic [FILT_W-1:0] cfg_filt_i,
    input  logic              demag_wr_i,
    input  logic [CNT_W-1:0]  demag_wdata_i,
    input  logic              irq_mask_i,
    input  logic              flag_clr_i,
    output logic              demag_evt_o,
    output logic              demag_flag_o,
    output logic              irq_o,
    output logic [CNT_W-1:0]  demag_val_o
);

    typedef struct packed {
        logic             armed;
        logic             chk;
        logic             evt;
        logic             flag;
        logic [CNT_W-1:0] dreg;
        logic [CNT_W-1:0] dpre;
    } gen_t;

    gen_t              st_d, st_q;
    mode_t             act_mode;
    logic [FILT_W-1:0] act_filt;
    logic              filt_hit;
    logic              hw_hit, sim_hit, late_hit, fire;
    src_e              src;

    demag_cfg_shadow #(.FILT_W(FILT_W)) i_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr_i),
        .hw_en_i    (cfg_hw_en_i),
        .sim_en_i   (cfg_sim_en_i),
        .filt_i     (cfg_filt_i),
        .comm_i     (comm_i),
        .act_mode_o (act_mode),
        .act_filt_o (act_filt)
    );

    demag_edge_filter #(.FILT_W(FILT_W)) i_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .comm_i      (comm_i),
        .sample_en_i (sample_en_i),
        .sense_i     (sense_i),
        .rising_i    (rising_i),
        .filt_i      (act_filt),
        .hit_o       (filt_hit)
    );

    assign hw_hit   = act_mode.hw_en && filt_hit;
    assign sim_hit  = act_mode.sim_en && (count_i == st_q.dreg);
    assign late_hit = st_q.chk && act_mode.sim_en && (st_q.dreg <= count_i);
    assign fire     = st_q.armed && !comm_i && (hw_hit || sim_hit || late_hit);

    always_comb begin
        if (!fire)         src = SRC_NONE;
        else if (late_hit) src = SRC_LATE;
        else if (hw_hit)   src = SRC_HW;
        else               src = SRC_SIM;
    end

    always_comb begin
        st_d = st_q;
        if (demag_wr_i) st_d.dpre = demag_wdata_i;
        if (src == SRC_LATE || src == SRC_HW) st_d.dreg = count_i;
        else if (rupd_i)                      st_d.dreg = st_q.dpre;
        if (comm_i)    st_d.armed = 1'b1;
        else if (fire) st_d.armed = 1'b0;
        st_d.chk = comm_i;
        st_d.evt = fire;
        if (fire)            st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign demag_evt_o  = st_q.evt;
    assign demag_flag_o = st_q.flag;
    assign irq_o        = st_q.flag && irq_mask_i;
    assign demag_val_o  = st_q.dreg;

    // R7
    evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |=> !st_q.evt);

    // R10
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> st_q.flag);

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !flag_clr_i) |=> st_q.flag);

    // R9
    late_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && st_q.chk && act_mode.sim_en && !comm_i && (st_q.dreg <= count_i))
        |=> (st_q.evt && st_q.dreg == $past(count_i)));

    // R4
    hw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !comm_i && act_mode.hw_en && filt_hit)
        |=> (st_q.evt && st_q.dreg == $past(count_i)));

endmodule

// File: tb/test_demag_event_gen.sv
module test_demag_event_gen;

    localparam int unsigned CNT_W  = 8;
    localparam int unsigned FILT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              comm_i = 0, rupd_i = 0, sample_en_i = 0, sense_i = 0, rising_i = 1;
    logic [CNT_W-1:0]  count_i = '0;
    logic              cfg_wr_i = 0, cfg_hw_en_i = 0, cfg_sim_en_i = 0;
    logic [FILT_W-1:0] cfg_filt_i = '0;
    logic              demag_wr_i = 0;
    logic [CNT_W-1:0]  demag_wdata_i = '0;
    logic              irq_mask_i = 0, flag_clr_i = 0;
    logic              demag_evt_o, demag_flag_o, irq_o;
    logic [CNT_W-1:0]  demag_val_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    demag_event_gen #(.CNT_W(CNT_W), .FILT_W(FILT_W)) i_demag_event_gen (.*);

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            finish_up();
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic commutate();
        comm_i = 1; count_i = '0; sample_en_i = 0;
        tick();
        comm_i = 0;
    endtask

    task automatic write_cfg(input logic hw, input logic sim, input logic [FILT_W-1:0] f);
        cfg_wr_i = 1; cfg_hw_en_i = hw; cfg_sim_en_i = sim; cfg_filt_i = f;
        tick();
        cfg_wr_i = 0;
    endtask

    task automatic load_demag(input logic [CNT_W-1:0] v);
        demag_wr_i = 1; demag_wdata_i = v;
        tick();
        demag_wr_i = 0; rupd_i = 1;
        tick();
        rupd_i = 0;
    endtask

    task automatic t_reset();
        chk("R1", "evt", demag_evt_o, 0);
        chk("R1", "flag", demag_flag_o, 0);
        chk("R1", "irq", irq_o, 0);
        chk("R1", "val", demag_val_o, 0);
    endtask

    task automatic t_sim_and_preload();
        int nevt = 0;
        load_demag(8'd5);
        chk("R8", "val after update", demag_val_o, 5);
        for (int k = 1; k <= 8; k++) begin
            count_i = k[CNT_W-1:0];
            tick();
            if (demag_evt_o) nevt++;
        end
        chk("R7", "events before first commutation", nevt, 0);
        commutate();
        write_cfg(1'b0, 1'b1, '0);
        nevt = 0;
        for (int k = 1; k <= 8; k++) begin
            count_i = k[CNT_W-1:0];
            tick();
            if (demag_evt_o) nevt++;
        end
        chk("R2", "events with staged but inactive mode", nevt, 0);
        commutate();
        for (int k = 1; k <= 10; k++) begin
            count_i = k[CNT_W-1:0];
            tick();
            chk("R5", $sformatf("evt at count %0d", k), demag_evt_o, (k == 5) ? 1 : 0);
        end
        chk("R10", "flag after event", demag_flag_o, 1);
        chk("R10", "irq masked", irq_o, 0);
        irq_mask_i = 1;
        #1;
        chk("R10", "irq unmasked", irq_o, 1);
        flag_clr_i = 1;
        tick();
        flag_clr_i = 0;
        chk("R10", "flag cleared", demag_flag_o, 0);
        chk("R10", "irq after clear", irq_o, 0);
        commutate();
        for (int k = 1; k <= 6; k++) begin
            count_i = k[CNT_W-1:0];
            flag_clr_i = (k == 5);
            tick();
        end
        flag_clr_i = 0;
        chk("R10", "set wins over clear", demag_flag_o, 1);
        flag_clr_i = 1;
        tick();
        flag_clr_i = 0;
    endtask

    task automatic t_late();
        commutate();
        count_i = 8'd7;
        tick();
        chk("R9", "late evt (5<=7)", demag_evt_o, 1);
        chk("R9", "late overwrite", demag_val_o, 7);
        for (int k = 8; k <= 10; k++) begin
            count_i = k[CNT_W-1:0];
            tick();
            chk("R7", "no second evt", demag_evt_o, 0);
        end
        commutate();
        count_i = 8'd7;
        tick();
        chk("R9", "late evt equal", demag_evt_o, 1);
        commutate();
        count_i = 8'd6;
        tick();
        chk("R9", "no late evt when above count", demag_evt_o, 0);
        chk("R9", "val kept", demag_val_o, 7);
        count_i = 8'd7;
        tick();
        chk("R5", "compare evt after late check", demag_evt_o, 1);
    endtask

    task automatic t_hw();
        logic s [9] = '{0, 1, 1, 0, 1, 1, 1, 1, 1};
        write_cfg(1'b1, 1'b0, 4'd2);
        commutate();
        for (int k = 0; k < 9; k++) begin
            sample_en_i = 1; sense_i = s[k]; count_i = 8'(k + 1);
            tick();
            chk("R3", $sformatf("hw evt at sample %0d", k), demag_evt_o, (k == 6) ? 1 : 0);
        end
        chk("R4", "captured count", demag_val_o, 7);
        commutate();
        for (int k = 1; k <= 5; k++) begin
            sample_en_i = 1; sense_i = 1; count_i = k[CNT_W-1:0];
            tick();
            chk("R3", "no evt without prior inactive level", demag_evt_o, 0);
        end
        rising_i = 0;
        commutate();
        for (int k = 0; k < 4; k++) begin
            sample_en_i = 1; sense_i = (k == 0); count_i = 8'(k + 1);
            tick();
            chk("R3", $sformatf("falling evt at sample %0d", k), demag_evt_o, (k == 3) ? 1 : 0);
        end
        chk("R4", "captured count falling", demag_val_o, 4);
        rising_i = 1; sample_en_i = 0; sense_i = 0;
    endtask

    task automatic t_both();
        int nevt = 0;
        write_cfg(1'b1, 1'b1, 4'd0);
        load_demag(8'd20);
        commutate();
        for (int k = 1; k <= 22; k++) begin
            sample_en_i = 1; sense_i = (k >= 2); count_i = k[CNT_W-1:0];
            tick();
            if (demag_evt_o) begin
                nevt++;
                chk("R6", "hw wins first", k, 2);
            end
        end
        chk("R6", "single event in step", nevt, 1);
        chk("R4", "captured on hw win", demag_val_o, 2);
        sense_i = 0;
        commutate();
        nevt = 0;
        for (int k = 1; k <= 6; k++) begin
            sample_en_i = 1; sense_i = (k >= 3); count_i = k[CNT_W-1:0];
            tick();
            if (demag_evt_o) begin
                nevt++;
                chk("R6", "compare wins first", k, 2);
            end
        end
        chk("R7", "later edge ignored", nevt, 1);
        chk("R7", "val unchanged by ignored edge", demag_val_o, 2);
        sample_en_i = 0;
    endtask

    initial begin
        #1;
        t_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        tick();
        t_reset();
        t_sim_and_preload();
        t_late();
        t_hw();
        t_both();
        finish_up();
    end

endmodule